// File: doc/BRIEF.md
# Zero-Turnaround Late-Write SRAM Core

A synchronous single-port on-chip memory with registered commands. One read or write command is taken on every rising clock edge, with no idle cycles between a read and a write. The write address and byte enables are captured with the command. The write data follows later on the same data input. The core holds each write address in a short internal pipeline until its data arrives. Any read that targets a write still in that pipeline gets the new data, merged lane by lane with the array contents.

A static mode input sets the timing. In registered mode, read data passes through an output register, and write data is due two edges after the command. In direct mode, read data leaves the array combinationally, and write data is due one edge after the command. A burst sequencer can continue the current operation from an internal 2-bit beat counter. It steps in linear or XOR order and wraps on a four-word boundary. Three chip enables gate new commands. An asynchronous output enable and a sleep input blank the data output.

Top module: `zbt_sram_core`

## Requirements
- R1: Every input is sampled only on the rising edge of `clk_i`. A read or write command is accepted on every edge, and any mix of reads and writes runs back to back with no idle edge.
- R2: With `pipe_mode_i`=1, a read accepted at edge k shows its data on `rdata_o`, with `rdata_oe_o`=1, from edge k+1 until edge k+2.
- R3: With `pipe_mode_i`=0, a read accepted at edge k shows its data from edge k until edge k+1.
- R4: With `pipe_mode_i`=1, the data for a write accepted at edge k is taken from `wdata_i` at edge k+2.
- R5: With `pipe_mode_i`=0, the data for a write accepted at edge k is taken from `wdata_i` at edge k+1.
- R6: `byte_en_i` is sampled with the write command. Bit j set means bits [9j+8:9j] are written. Lanes whose bit is clear keep their old contents.
- R7: A new command is accepted only when `ce_a_ni`=0, `ce_b_i`=1 and `ce_c_ni`=0. Any other combination with `adv_i`=0 deselects the core: no read output follows, no write occurs, and a burst in progress ends.
- R8: With `adv_i`=1, the previous operation continues at the next beat of the burst, and chip enables, `wr_i` and `addr_i` are ignored. Beat n replaces the low two address bits b with (b+n) mod 4 when `lin_order_i`=1, or with b XOR n when `lin_order_i`=0. The sequence wraps after four beats. Advancing after a deselect does nothing.
- R9: While `oe_ni`=1, `rdata_oe_o` is 0 and `rdata_o` is all zeros, asynchronously.
- R10: While `sleep_i`=1, edges accept no command (advance included), any burst ends, and the outputs are blanked as in R9. Writes accepted before the sleep still take their data.
- R11: A read returns, for each lane, the data of the latest write accepted before it. This holds even when that write's data reaches `wdata_i` at the same edge the read data is captured.
- R12: While `rst_ni`=0, asynchronously, pending reads and writes are dropped, `rdata_oe_o` is 0, and the burst state is idle. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | 1 = registered read / two-edge write data; 0 = direct read / one-edge write data |
| lin_order_i | input | 1 | Burst order: 1 linear, 0 XOR |
| ce_a_ni | input | 1 | Chip enable, active low |
| ce_b_i | input | 1 | Chip enable, active high |
| ce_c_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | Continue burst instead of loading a command |
| wr_i | input | 1 | 1 = write, 0 = read on a loaded command |
| addr_i | input | ADDR_W | Command address |
| byte_en_i | input | NBYTE | Write lane enables, one per 9-bit lane |
| wdata_i | input | 9*NBYTE | Late write data |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep: ignore commands, blank outputs |
| rdata_o | output | 9*NBYTE | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Read data valid and driven |

## Verification
The stimulus is a random mix of loaded reads, loaded writes, advances, deselects and sleep cycles. It uses a narrow address window, so reads often land on writes that are still waiting for data. A wrong write delay or a missing bypass then shows up as a stale or mixed lane. Directed sequences cover:
- a burst from a base whose low bits are 01, which separates linear order from XOR order;
- a write with no lanes enabled;
- alternating partial-lane writes followed at once by reads.

Every mode and order pairing is run in turn, with a reset between runs. Random assertion of output enable and sleep checks that blanking overrides the read data that would otherwise be driven.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int unsigned LANE_W = 9;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sleep_i,
  input  logic              adv_i,
  input  logic              wr_i,
  input  logic              lin_order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nxt;
  op_e               op_q;

  function automatic logic [1:0] beat_low(logic [1:0] b, logic [1:0] n, logic lin);
    return lin ? (b + n) : (b ^ n);
  endfunction

  assign cnt_nxt = cnt_q + 2'd1;

  always_comb begin
    cmd_op_o   = OP_IDLE;
    cmd_addr_o = addr_i;
    if (!sleep_i) begin
      if (adv_i) begin
        cmd_op_o   = op_q;
        cmd_addr_o = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_nxt, lin_order_i)};
      end else if (sel_i) begin
        cmd_op_o = wr_i ? OP_WRITE : OP_READ;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (sleep_i) begin
      op_q <= OP_IDLE;
    end else if (adv_i) begin
      cnt_q <= cnt_nxt;
    end else begin
      op_q   <= sel_i ? (wr_i ? OP_WRITE : OP_READ) : OP_IDLE;
      base_q <= addr_i;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/zbt_late_write.sv
module zbt_late_write
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NBYTE  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_i,
  input  op_e               cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [NBYTE-1:0]  cmd_be_i,
  output logic              commit_en_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [NBYTE-1:0]  commit_be_o
);
  localparam int unsigned STAGES = 2;

  typedef struct packed {
    logic              v;
    logic [ADDR_W-1:0] a;
    logic [NBYTE-1:0]  be;
  } stg_t;

  stg_t stg_q [STAGES];
  stg_t head;
  stg_t sel;

  assign head = '{v: (cmd_op_i == OP_WRITE), a: cmd_addr_i, be: cmd_be_i};

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= head;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  // registered mode retires from the last stage, direct mode from the first
  assign sel           = pipe_i ? stg_q[STAGES-1] : stg_q[0];
  assign commit_en_o   = sel.v;
  assign commit_addr_o = sel.a;
  assign commit_be_o   = sel.be;
endmodule

// File: rtl/zbt_array.sv
module zbt_array
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NBYTE  = 2
) (
  input  logic                      clk_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         waddr_i,
  input  logic [NBYTE-1:0]          wbe_i,
  input  logic [NBYTE*LANE_W-1:0]   wdata_i,
  input  logic [ADDR_W-1:0]         raddr_i,
  output logic [NBYTE*LANE_W-1:0]   rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < NBYTE; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/zbt_read_path.sv
module zbt_read_path
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NBYTE  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_i,
  input  logic                    rd_issue_i,
  input  logic [ADDR_W-1:0]       cmd_addr_i,
  output logic [ADDR_W-1:0]       rd_addr_o,
  input  logic [NBYTE*LANE_W-1:0] arr_rdata_i,
  input  logic                    byp_en_i,
  input  logic [ADDR_W-1:0]       byp_addr_i,
  input  logic [NBYTE-1:0]        byp_be_i,
  input  logic [NBYTE*LANE_W-1:0] wdata_i,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  output logic [NBYTE*LANE_W-1:0] rdata_o,
  output logic                    rdata_oe_o
);
  localparam int unsigned DW = NBYTE * LANE_W;

  logic              rd_v_q, out_v_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DW-1:0]     out_q, merged, data;
  logic              hit, active;

  // data landing at the capture edge belongs to an older write
  assign hit = pipe_i && byp_en_i && (byp_addr_i == rd_addr_q);

  for (genvar l = 0; l < NBYTE; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = (hit && byp_be_i[l]) ? wdata_i[l*LANE_W +: LANE_W]
                                                              : arr_rdata_i[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_v_q    <= 1'b0;
      rd_addr_q <= '0;
      out_v_q   <= 1'b0;
      out_q     <= '0;
    end else begin
      rd_v_q  <= rd_issue_i;
      out_v_q <= pipe_i && rd_v_q;
      if (rd_issue_i)         rd_addr_q <= cmd_addr_i;
      if (pipe_i && rd_v_q)   out_q     <= merged;
    end
  end

  assign rd_addr_o  = rd_addr_q;
  assign active     = pipe_i ? out_v_q : rd_v_q;
  assign data       = pipe_i ? out_q : arr_rdata_i;
  assign rdata_oe_o = active && !oe_ni && !sleep_i;
  assign rdata_o    = rdata_oe_o ? data : '0;
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NBYTE  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_mode_i,
  input  logic                    lin_order_i,
  input  logic                    ce_a_ni,
  input  logic                    ce_b_i,
  input  logic                    ce_c_ni,
  input  logic                    adv_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [NBYTE-1:0]        byte_en_i,
  input  logic [NBYTE*LANE_W-1:0] wdata_i,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  output logic [NBYTE*LANE_W-1:0] rdata_o,
  output logic                    rdata_oe_o
);
  localparam int unsigned DW = NBYTE * LANE_W;

  logic              sel;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic              rd_issue;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [NBYTE-1:0]  commit_be;
  logic [ADDR_W-1:0] rd_addr;
  logic [DW-1:0]     arr_rdata;

  assign sel      = !ce_a_ni && ce_b_i && !ce_c_ni;
  assign rd_issue = (cmd_op == OP_READ);

  zbt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel),
    .sleep_i     (sleep_i),
    .adv_i       (adv_i),
    .wr_i        (wr_i),
    .lin_order_i (lin_order_i),
    .addr_i      (addr_i),
    .cmd_op_o    (cmd_op),
    .cmd_addr_o  (cmd_addr)
  );

  zbt_late_write #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) u_lw (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pipe_i        (pipe_mode_i),
    .cmd_op_i      (cmd_op),
    .cmd_addr_i    (cmd_addr),
    .cmd_be_i      (byte_en_i),
    .commit_en_o   (commit_en),
    .commit_addr_o (commit_addr),
    .commit_be_o   (commit_be)
  );

  zbt_array #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) u_arr (
    .clk_i   (clk_i),
    .we_i    (commit_en),
    .waddr_i (commit_addr),
    .wbe_i   (commit_be),
    .wdata_i (wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (arr_rdata)
  );

  zbt_read_path #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pipe_i      (pipe_mode_i),
    .rd_issue_i  (rd_issue),
    .cmd_addr_i  (cmd_addr),
    .rd_addr_o   (rd_addr),
    .arr_rdata_i (arr_rdata),
    .byp_en_i    (commit_en),
    .byp_addr_i  (commit_addr),
    .byp_be_i    (commit_be),
    .wdata_i     (wdata_i),
    .oe_ni       (oe_ni),
    .sleep_i     (sleep_i),
    .rdata_o     (rdata_o),
    .rdata_oe_o  (rdata_oe_o)
  );
endmodule

// File: rtl/zbt_sram_core_chk.sv
module zbt_sram_core_chk
  import zbt_pkg::*;
#(
  parameter int unsigned DW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pipe_mode_i,
  input logic          oe_ni,
  input logic          sleep_i,
  input logic [DW-1:0] rdata_o,
  input logic          rdata_oe_o,
  input op_e           cmd_op,
  input logic          commit_en
);
  AST_OE_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!rdata_oe_o && rdata_o == '0)); // R9

  AST_SLEEP_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !rdata_oe_o); // R10

  AST_SLEEP_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !pipe_mode_i) |=> !commit_en); // R10

  AST_DIRECT_RD_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && cmd_op == OP_READ) |=> (rdata_oe_o || oe_ni || sleep_i)); // R3

  AST_REG_RD_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && cmd_op == OP_READ) |=> ##1 (rdata_oe_o || oe_ni || sleep_i)); // R2

  AST_DIRECT_WR_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && cmd_op == OP_WRITE) |=> commit_en); // R5

  AST_REG_WR_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && cmd_op == OP_WRITE) |=> ##1 commit_en); // R4
endmodule

bind zbt_sram_core zbt_sram_core_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pipe_mode_i (pipe_mode_i),
  .oe_ni       (oe_ni),
  .sleep_i     (sleep_i),
  .rdata_o     (rdata_o),
  .rdata_oe_o  (rdata_oe_o),
  .cmd_op      (cmd_op),
  .commit_en   (commit_en)
);

// File: tb/zbt_sram_core_bench.sv
module zbt_sram_core_bench;
  localparam int AW = 8;
  localparam int NB = 2;
  localparam int DW = NB * 9;
  localparam int K_RD = 0, K_WR = 1, K_ADV = 2, K_DES = 3, K_SLP = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pipe_mode_i = 1'b1, lin_order_i = 1'b1;
  logic ce_a_ni = 1'b1, ce_b_i = 1'b0, ce_c_ni = 1'b1;
  logic adv_i = 1'b0, wr_i = 1'b0, oe_ni = 1'b0, sleep_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [NB-1:0] byte_en_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rdata_oe_o;

  always #5 clk = ~clk;

  zbt_sram_core #(.ADDR_W(AW), .NBYTE(NB)) u_zbt_sram_core (
    .clk_i(clk), .rst_ni(rst_ni), .pipe_mode_i(pipe_mode_i), .lin_order_i(lin_order_i),
    .ce_a_ni(ce_a_ni), .ce_b_i(ce_b_i), .ce_c_ni(ce_c_ni), .adv_i(adv_i), .wr_i(wr_i),
    .addr_i(addr_i), .byte_en_i(byte_en_i), .wdata_i(wdata_i), .oe_ni(oe_ni),
    .sleep_i(sleep_i), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  int n_tests = 0, n_fail = 0;
  int unsigned cyc = 0;
  bit done = 0;
  logic [DW-1:0] model [1<<AW];
  logic [DW-1:0] wsch  [64];
  logic          exp_v [64];
  logic [DW-1:0] exp_d [64];
  string         exp_t [64];
  int            b_op = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;
  logic [AW-1:0] hist_a [2];
  logic          hist_v [2];

  function automatic logic [AW-1:0] beat(logic [AW-1:0] b, logic [1:0] n, logic lin);
    logic [1:0] lo;
    lo = lin ? (b[1:0] + n) : (b[1:0] ^ n);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] be);
    logic [DW-1:0] r;
    r = old;
    for (int l = 0; l < NB; l++) if (be[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic act_oe, logic [DW-1:0] act, logic exp_oe, logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d: actual oe=%0b data=%h expected oe=%0b data=%h",
               tag, cyc, act_oe, act, exp_oe, exp);
    end
  endtask

  // one edge: sample the window before it, then drive the command for it (R1)
  task automatic step(int kind, logic [AW-1:0] a, logic [NB-1:0] be, bit oe_off);
    int idx, tgt, lat;
    bit blank, is_rd, is_wr;
    logic [AW-1:0] ea;
    logic [DW-1:0] wd;
    string tg;
    @(negedge clk);
    idx   = cyc % 64;
    blank = oe_ni || sleep_i;
    if (exp_v[idx] && !blank)
      check(rdata_oe_o === 1'b1 && rdata_o === exp_d[idx], exp_t[idx], rdata_oe_o, rdata_o, 1'b1, exp_d[idx]);
    else
      check(rdata_oe_o === 1'b0 && rdata_o === '0, oe_ni ? "R9" : (sleep_i ? "R10" : "R7"),
            rdata_oe_o, rdata_o, 1'b0, '0);
    exp_v[idx] = 1'b0;
    lat = pipe_mode_i ? 2 : 1;
    tgt = (cyc + lat) % 64;
    wdata_i = wsch[idx];
    wsch[tgt] = DW'($urandom);
    adv_i = 1'b0; sleep_i = 1'b0; oe_ni = oe_off; wr_i = 1'($urandom);
    addr_i = a; byte_en_i = be;
    ce_a_ni = 1'b0; ce_b_i = 1'b1; ce_c_ni = 1'b0;
    is_rd = 0; is_wr = 0; ea = a; tg = "";
    case (kind)
      K_RD, K_WR: begin
        wr_i = (kind == K_WR); b_op = (kind == K_WR) ? 2 : 1; b_base = a; b_cnt = 0;
        is_rd = (kind == K_RD); is_wr = (kind == K_WR);
      end
      K_ADV: begin // R8: enables and wr_i are don't-care
        adv_i = 1'b1; ce_a_ni = 1'($urandom); ce_b_i = 1'($urandom);
        if (b_op != 0) begin
          b_cnt = b_cnt + 2'd1; ea = beat(b_base, b_cnt, lin_order_i);
          is_rd = (b_op == 1); is_wr = (b_op == 2); tg = "R8";
        end
      end
      K_DES: begin // R7: one enable inactive
        case ($urandom % 3)
          0: ce_a_ni = 1'b1;
          1: ce_b_i  = 1'b0;
          default: ce_c_ni = 1'b1;
        endcase
        b_op = 0;
      end
      default: begin // R10: sleep overrides a live command or advance
        sleep_i = 1'b1; adv_i = 1'($urandom); b_op = 0;
      end
    endcase
    if (is_wr) begin
      wd = wsch[tgt];
      model[ea] = merge(model[ea], wd, be); // R6
    end
    if (is_rd) begin
      if (tg == "") begin
        tg = pipe_mode_i ? "R2" : "R3";
        if ((hist_v[0] && hist_a[0] == ea) || (pipe_mode_i && hist_v[1] && hist_a[1] == ea)) tg = "R11";
      end
      exp_v[tgt] = 1'b1; exp_d[tgt] = model[ea]; exp_t[tgt] = tg;
    end
    hist_a[1] = hist_a[0]; hist_v[1] = hist_v[0];
    hist_a[0] = ea;        hist_v[0] = is_wr;
    cyc++;
  endtask

  task automatic do_reset(bit pm, bit lo);
    for (int i = 0; i < 3; i++) step(K_DES, '0, '0, 1'b0); // drain
    @(negedge clk);
    rst_ni = 1'b0; pipe_mode_i = pm; lin_order_i = lo;
    ce_a_ni = 1'b0; ce_b_i = 1'b1; ce_c_ni = 1'b0; oe_ni = 1'b0; sleep_i = 1'b0;
    for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
    hist_v[0] = 0; hist_v[1] = 0; b_op = 0;
    repeat (2) @(negedge clk);
    check(rdata_oe_o === 1'b0, "R12", rdata_oe_o, rdata_o, 1'b0, '0);
    ce_a_ni = 1'b1;
    rst_ni = 1'b1;
  endtask

  task automatic directed();
    logic [AW-1:0] a;
    a = 8'h25; // low bits 01: linear 5,6,7,4 vs xor 5,4,7,6
    step(K_RD, a, 2'b00, 1'b0);
    for (int i = 0; i < 5; i++) step(K_ADV, 8'hff, 2'b11, 1'b0);
    step(K_WR, a, 2'b11, 1'b0);
    for (int i = 0; i < 3; i++) step(K_ADV, 8'h00, 2'(i + 1), 1'b0);
    for (int i = 0; i < 4; i++) step(K_RD, {a[AW-1:2], 2'(i)}, 2'b00, 1'b0);
    step(K_WR, 8'h40, 2'b01, 1'b0); step(K_RD, 8'h40, 2'b00, 1'b0); // R11 partial lanes
    step(K_WR, 8'h40, 2'b10, 1'b0); step(K_RD, 8'h40, 2'b00, 1'b0);
    step(K_WR, 8'h40, 2'b00, 1'b0); step(K_RD, 8'h40, 2'b00, 1'b0); // R6 no lanes
    step(K_RD, 8'h40, 2'b00, 1'b0); step(K_RD, 8'h40, 2'b00, 1'b1); // R9
    step(K_SLP, 8'h40, 2'b11, 1'b0); step(K_ADV, 8'h41, 2'b11, 1'b0); // R10 burst ended
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      int r, k;
      r = $urandom % 100;
      k = (r < 28) ? K_RD : (r < 55) ? K_WR : (r < 80) ? K_ADV : (r < 91) ? K_DES : K_SLP;
      step(k, AW'($urandom % 16), NB'($urandom), ($urandom % 12) == 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) begin exp_v[i] = 0; wsch[i] = '0; end
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    hist_v[0] = 0; hist_v[1] = 0; hist_a[0] = '0; hist_a[1] = '0;
    repeat (3) @(negedge clk);
    check(rdata_oe_o === 1'b0, "R12", rdata_oe_o, rdata_o, 1'b0, '0);
    rst_ni = 1'b1;
    for (int i = 0; i < (1 << AW); i++) step(K_WR, AW'(i), 2'b11, 1'b0); // fill
    for (int m = 0; m < 4; m++) begin
      do_reset(m < 2, m[0] == 1'b0);
      directed();
      random_run(1200);
    end
    for (int i = 0; i < 3; i++) step(K_DES, '0, '0, 1'b0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(10 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule